// File: doc/BRIEF.md
# Register-File Bus Slave on a Two-Wire Serial Bus

This block is a two-wire serial (I2C) slave that owns a small file of byte registers and lets an external bus master read and write them. SCL and SDA are sampled with the fast system clock, so no logic runs on the bus clock. START, repeated START and STOP conditions are recognised at any point. SDA is driven only through an open-drain enable, and the bus line is pulled low when `sda_oe` is high.

A write transfer carries the device address with direction 0, then a pointer byte, then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps forward. A read transfer returns bytes from the current pointer onward. The pointer is kept between transfers. A master can therefore set it in a write, issue a repeated START, and read back from that location. Local logic sees every bus write as a one-cycle strobe that carries the register index and the byte. It also sees the pointer and the register it selects on a combinational read path.

Top module: `i2c_reg_slave`

## Requirements
- R1: Only the 7-bit address 1101000 is answered. After any other address byte the slave acknowledges nothing, sends nothing (SDA stays released) and writes nothing until the next START.
- R2: Bit 0 of the address byte (the last bit received) gives the direction: 0 (byte D0h) is a write and 1 (byte D1h) is a read.
- R3: Bytes go MSB first in both directions. The address is judged only after all eight bits of the address byte have arrived.
- R4: In a write, the slave holds SDA low through the ninth SCL pulse after the address byte and after every data byte.
- R5: In a write, the first byte after the address loads the pointer from its low 4 bits. Each later byte is stored at the pointer, and the pointer then advances by one. Each store raises `wr_stb` for exactly one cycle, with `wr_addr` set to the register index and `wr_data` set to the byte.
- R6: In a read, the slave sends the register at the pointer and then advances the pointer. It goes on sending after each master ACK (SDA low on the ninth pulse). After a NACK (SDA high) it releases SDA and sends nothing more.
- R7: There are 16 registers. The pointer wraps from 15 to 0 in both reads and writes. It keeps its value across STOP and START until a write loads it again.
- R8: A repeated START, even with no STOP before it, makes the next byte an address byte.
- R9: A STOP anywhere, including mid-byte, ends the transfer: SDA is released and no store happens.
- R10: After reset the pointer and all registers are 0, SDA is released and `wr_stb` is low.
- R11: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| wr_stb | output | 1 | One-cycle pulse for each register stored from the bus |
| wr_addr | output | 4 | Index of the register being stored |
| wr_data | output | 8 | Byte being stored |
| ptr_o | output | 4 | Current register pointer |
| rd_data | output | 8 | Register selected by the pointer (combinational) |

## Verification
The hardest case to reach is a pointer that survives across transfer boundaries while also wrapping. A write loads pointer 15 and stores across the wrap, then ends with STOP. A fresh read transfer must then continue from the stored pointer and wrap as it goes. A second sequence sets the pointer in a write and, without a STOP, issues a repeated START into a read. A STOP placed mid-byte and address bytes that differ from the device address in a single bit check that aborted or foreign transfers leave the pointer and the registers untouched.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         NREG     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  output logic                     wr_stb,
  output logic [$clog2(NREG)-1:0]  wr_addr,
  output logic [7:0]               wr_data,
  output logic [$clog2(NREG)-1:0]  ptr_o,
  output logic [7:0]               rd_data
);
  localparam int AW = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;

  logic [2:0]    scl_p, sda_p;
  st_t           state;
  logic [3:0]    cnt;
  logic [7:0]    rx, tx;
  logic          first, rd, have_ptr, nack;
  logic [AW-1:0] ptr, ptr_nx;
  logic [7:0]    regs [NREG];

  wire scl_q   = scl_p[1];
  wire scl_d   = scl_p[2];
  wire sda_q   = sda_p[1];
  wire sda_d   = sda_p[2];
  wire rise    = scl_q & ~scl_d;
  wire fall    = ~scl_q & scl_d;
  wire start_c = scl_q & scl_d & sda_d & ~sda_q;
  wire stop_c  = scl_q & scl_d & ~sda_d & sda_q;

  assign ptr_nx  = (ptr == AW'(NREG - 1)) ? '0 : ptr + 1'b1;
  assign ptr_o   = ptr;
  assign rd_data = regs[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      rx       <= '0;
      tx       <= '0;
      first    <= 1'b0;
      rd       <= 1'b0;
      have_ptr <= 1'b0;
      nack     <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        state  <= S_RX;
        cnt    <= '0;
        first  <= 1'b1;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (rise) begin
              rx  <= {rx[6:0], sda_q};
              cnt <= cnt + 1'b1;
            end else if (fall && cnt == 4'd8) begin
              cnt <= '0;
              if (first) begin
                first <= 1'b0;
                if (rx[7:1] == DEV_ADDR) begin
                  sda_oe   <= 1'b1;
                  rd       <= rx[0];
                  have_ptr <= 1'b0;
                  state    <= S_RACK;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= S_RACK;
                if (!have_ptr) begin
                  ptr      <= rx[AW-1:0];
                  have_ptr <= 1'b1;
                end else begin
                  regs[ptr] <= rx;
                  wr_stb    <= 1'b1;
                  wr_addr   <= ptr;
                  wr_data   <= rx;
                  ptr       <= ptr_nx;
                end
              end
            end
          end
          S_RACK: begin
            if (rise) cnt <= 4'd1;
            else if (fall && cnt == 4'd1) begin
              cnt <= '0;
              if (rd) begin
                tx     <= regs[ptr];
                sda_oe <= ~regs[ptr][7];
                ptr    <= ptr_nx;
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (rise) cnt <= cnt + 1'b1;
            else if (fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= S_TACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          S_TACK: begin
            if (rise) begin
              cnt  <= 4'd1;
              nack <= sda_q;
            end else if (fall && cnt == 4'd1) begin
              cnt <= '0;
              if (nack) begin
                state <= S_IDLE;
              end else begin
                tx     <= regs[ptr];
                sda_oe <= ~regs[ptr][7];
                ptr    <= ptr_nx;
                state  <= S_TX;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == S_IDLE && !sda_oe));

  assert_restart_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == S_RX && cnt == 4'd0 && first));

  assert_store_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ptr == ((wr_addr == AW'(NREG - 1)) ? '0 : wr_addr + 1'b1)));

  assert_master_ack_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TACK) |-> !sda_oe);

  assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe, wr_stb;
  logic [3:0] wr_addr, ptr_o;
  logic [7:0] wr_data, rd_data;
  wire        sda_bus = m_sda & ~sda_oe;

  int total = 0;
  int bad = 0;
  int n_stb = 0;
  int viol = 0;
  logic [3:0] stb_a [16];
  logic [7:0] stb_d [16];
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;

  i2c_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_o(ptr_o), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      if (n_stb < 16) begin
        stb_a[n_stb] = wr_addr;
        stb_d[n_stb] = wr_data;
      end
      n_stb = n_stb + 1;
    end
    if (sda_oe && !oe_prev && m_scl) viol = viol + 1;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    m_sda = 1'b1; w(); m_scl = 1'b1; w(); m_sda = 1'b0; w(); m_scl = 1'b0; w();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; w(); m_scl = 1'b1; w(); m_sda = 1'b1; w();
  endtask

  task automatic m_wr(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(); m_scl = 1'b1; w(); m_scl = 1'b0; w();
    end
    m_sda = 1'b1; w(); m_scl = 1'b1; w();
    ack = !sda_bus;
    m_scl = 1'b0; w();
  endtask

  task automatic m_rd(input bit ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(); m_scl = 1'b1; w();
      b[i] = sda_bus;
      m_scl = 1'b0;
    end
    w(); m_sda = ack ? 1'b0 : 1'b1; w(); m_scl = 1'b1; w(); m_scl = 1'b0; w();
    m_sda = 1'b1;
  endtask

  task automatic t_reset();
    chk(ptr_o == 4'h0, "R10 pointer", ptr_o, 0);
    chk(rd_data == 8'h00, "R10 register", rd_data, 0);
    chk(!sda_oe, "R10 sda released", sda_oe, 0);
    chk(!wr_stb, "R10 strobe low", wr_stb, 0);
  endtask

  task automatic t_write();
    bit a;
    m_start();
    m_wr(8'hD0, a); chk(a, "R1 R2 R4 address ack", a, 1);
    m_wr(8'h03, a); chk(a, "R4 pointer byte ack", a, 1);
    m_wr(8'hA5, a); chk(a, "R4 data ack", a, 1);
    m_wr(8'h3C, a); chk(a, "R4 second data ack", a, 1);
    m_stop(); w();
    chk(n_stb == 2, "R5 strobe count", n_stb, 2);
    chk(stb_a[0] == 4'h3 && stb_d[0] == 8'hA5, "R5 first store", {stb_a[0], stb_d[0]}, 12'h3A5);
    chk(stb_a[1] == 4'h4 && stb_d[1] == 8'h3C, "R5 second store", {stb_a[1], stb_d[1]}, 12'h43C);
    chk(ptr_o == 4'h5, "R5 pointer advanced", ptr_o, 5);
    chk(rd_data == 8'h00, "R5 read path at pointer", rd_data, 0);
  endtask

  task automatic t_read_rstart();
    bit a;
    logic [7:0] b;
    m_start();
    m_wr(8'hD0, a); chk(a, "R4 address ack", a, 1);
    m_wr(8'h03, a); chk(a, "R5 pointer reload ack", a, 1);
    m_sda = 1'b1; w(); m_scl = 1'b1; w(); m_sda = 1'b0; w(); m_scl = 1'b0; w();
    m_wr(8'hD1, a); chk(a, "R8 address after repeated start", a, 1);
    m_rd(1'b1, b); chk(b == 8'hA5, "R3 R6 first read byte", b, 8'hA5);
    m_rd(1'b0, b); chk(b == 8'h3C, "R6 second read byte", b, 8'h3C);
    w();
    chk(!sda_oe, "R6 released after nack", sda_oe, 0);
    m_stop(); w();
    chk(ptr_o == 4'h5, "R6 pointer after read", ptr_o, 5);
    chk(n_stb == 2, "R2 read stores nothing", n_stb, 2);
  endtask

  task automatic t_foreign(input logic [7:0] adr);
    bit a;
    logic [7:0] b;
    m_start();
    m_wr(adr, a); chk(!a, "R1 foreign address no ack", a, 0);
    if (adr[0]) begin
      m_rd(1'b1, b); chk(b == 8'hFF, "R1 foreign read released", b, 8'hFF);
    end else begin
      m_wr(8'h07, a); chk(!a, "R1 foreign data no ack", a, 0);
      m_wr(8'h99, a); chk(!a, "R1 foreign data no ack 2", a, 0);
    end
    m_stop(); w();
    chk(n_stb == 2, "R1 no store", n_stb, 2);
    chk(ptr_o == 4'h5, "R1 pointer kept", ptr_o, 5);
  endtask

  task automatic t_wrap();
    bit a;
    logic [7:0] b;
    m_start();
    m_wr(8'hD0, a);
    m_wr(8'h0F, a);
    m_wr(8'h11, a); chk(a, "R4 ack at last register", a, 1);
    m_wr(8'h22, a);
    m_stop(); w();
    chk(stb_a[2] == 4'hF && stb_a[3] == 4'h0, "R7 write wrap", {stb_a[2], stb_a[3]}, 8'hF0);
    chk(ptr_o == 4'h1, "R7 pointer after wrap", ptr_o, 1);
    m_start();
    m_wr(8'hD0, a);
    m_wr(8'h0F, a);
    m_stop();
    m_start();
    m_wr(8'hD1, a); chk(a, "R2 read address ack", a, 1);
    m_rd(1'b1, b); chk(b == 8'h11, "R7 read from kept pointer", b, 8'h11);
    m_rd(1'b0, b); chk(b == 8'h22, "R7 read wraps", b, 8'h22);
    m_stop(); w();
    chk(ptr_o == 4'h1, "R7 pointer after read wrap", ptr_o, 1);
  endtask

  task automatic t_stop_mid();
    bit a;
    m_start();
    m_wr(8'hD0, a);
    m_wr(8'h08, a);
    for (int i = 3; i >= 0; i--) begin
      m_sda = i[0]; w(); m_scl = 1'b1; w(); m_scl = 1'b0; w();
    end
    m_stop(); w();
    chk(!sda_oe, "R9 released after stop", sda_oe, 0);
    chk(n_stb == 4, "R9 no store on partial byte", n_stb, 4);
    chk(ptr_o == 4'h8, "R9 pointer kept", ptr_o, 8);
    chk(viol == 0, "R11 drive only while scl low", viol, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_read_rstart();
    t_foreign(8'hA0);
    t_foreign(8'hD2);
    t_foreign(8'hD3);
    t_wrap();
    t_stop_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule